// File: doc/BRIEF.md
# LED Matrix Scan Sequencer

This block time-multiplexes a matrix of up to four rows and eighteen columns of LEDs. It turns on one row switch at a time and drives every column sink with a pulse-width window taken from that dot's 8-bit duty byte. Each row visit is built from three parts, in this order:

- a dark blanking gap, with every switch and sink off;
- a short column-delay window, with the row switch on and the sinks still off;
- a 256-step active window, in which each sink is on for its duty value out of 256 steps.

A scan-mode field sets how many rows are scanned. One mode code turns scanning off and uses the sinks alone. A 3-bit frequency code divides the step rate by a power of two. A phase bit shifts the upper half of the sinks by half an active window, so that fewer sinks switch at the same moment.

The duty bytes are supplied on one flat bus. The block only reads them, and never writes them. A run bit acts as a software shutdown. When it is low, every output is dark and the scan restarts from the first row. No stored duty value is disturbed.

Top module: `led_scan_seq`

## Requirements
- R1: At most one row switch enable (`sw_en`) is high in any cycle.
- R2: Each row visit lasts BLANK_STEPS steps with all outputs low, then DELAY_STEPS steps with only that row's switch high, then 256 active steps numbered p = 0..255. After reset or after `run` rises, the scan begins at the first blanking step of row 0.
- R3: Rows are visited in ascending order (`sw_en[0]` first) and wrap back to row 0. The row count depends on `scan_mode`: 4'b0001 scans 3 rows, 4'b0010 scans 2 rows, and 4'b0000 or any code not named in R3 or R4 scans 4 rows.
- R4: With `scan_mode` = 4'b0011, every switch enable stays low. The sinks repeat the row-0 visit timing and always use the row-0 duty bytes.
- R5: With `freq_code` = k for k from 1 to 6, one scan step takes 2^k clock cycles. Codes 3'b000 and 3'b111 give one step per cycle.
- R6: In active step p of row r, sink c is high exactly when p < D, where D is the byte at bits [8*(r*COLS+c) +: 8] of `duty_bytes` (dot address r*COLS+c+1). A byte of 0 keeps the sink dark, and 255 keeps it on for 255 of the 256 steps.
- R7: With `phase_180` = 1, sinks c >= COLS/2 are high exactly when ((p+128) mod 256) < D. Sinks below COLS/2 are unchanged.
- R8: While `run` is 0, all switch and sink enables are low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = scanning, 0 = software shutdown |
| scan_mode | input | 4 | Row-count / sink-only mode code |
| freq_code | input | 3 | Power-of-two step-rate divider code |
| phase_180 | input | 1 | Shift upper-half sinks by half a window |
| duty_bytes | input | 576 | All dot duty bytes, dot index r*COLS+c at bits [8*idx +: 8] |
| sw_en | output | 4 | Row switch enables, bit 0 = first row |
| cs_en | output | 18 | Column sink enables |

## Verification
The outputs are combinational from registered scan state. After N enabled rising edges with divider shift k, the outputs therefore show scan step floor(N / 2^k), and they stay stable until the next rising edge. The bench raises `run` just after a falling edge and queues one expected item for every later rising edge. A monitor pops and compares one item at each falling edge, which samples every cycle's result halfway between the edges that could change it. Dropping `run` is due to darken the outputs in the same cycle. The bench checks this at the first falling edge after the change, and checks that the scan restarts from the first blanking step when `run` returns.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

  localparam int DW      = 8;
  localparam int ROWS    = 4;
  localparam int PWM_LEN = 1 << DW;

  typedef enum logic [1:0] {
    PH_BLANK  = 2'd0,
    PH_DELAY  = 2'd1,
    PH_ACTIVE = 2'd2
  } scan_phase_e;

  // number of rows scanned for a scan mode code (sink-only counts as one)
  function automatic logic [2:0] rows_for_mode(input logic [3:0] mode);
    case (mode)
      4'b0001: return 3'd3;
      4'b0010: return 3'd2;
      4'b0011: return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  // log2 of clocks per step for a frequency code
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'b111) ? 3'd0 : code;
  endfunction

  // pulse window test: late sinks are shifted by half a window
  function automatic logic pwm_window(input logic [DW-1:0] cnt,
                                      input logic [DW-1:0] duty,
                                      input logic          late);
    logic [DW-1:0] c;
    c = late ? cnt + DW'(PWM_LEN / 2) : cnt;
    return c < duty;
  endfunction

endpackage

// File: rtl/scan_step_gen.sv
module scan_step_gen #(
  parameter int MAX_SHIFT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] freq_code,
  output logic       step
);
  import ledscan_pkg::*;

  localparam int CW = MAX_SHIFT;

  logic [2:0]    sh;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign sh   = div_shift(freq_code);
  assign lim  = (CW'(1) << sh) - CW'(1);
  assign step = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || step) cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (!step || div_shift(freq_code) == 3'd0)) else $error("step spacing"); // R5

endmodule

// File: rtl/scan_row_fsm.sv
module scan_row_fsm #(
  parameter int BLANK_STEPS = 6,
  parameter int DELAY_STEPS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     step,
  input  logic [3:0]               scan_mode,
  output ledscan_pkg::scan_phase_e phase,
  output logic [ledscan_pkg::DW-1:0] pos,
  output logic [$clog2(ledscan_pkg::ROWS)-1:0] row,
  output logic                     row_end,
  output logic                     sink_only
);
  import ledscan_pkg::*;

  localparam int RW = $clog2(ROWS);

  logic [DW-1:0] last_pos;
  logic [2:0]    nrows;
  logic          at_last;

  assign sink_only = (scan_mode == 4'b0011);
  assign nrows     = rows_for_mode(scan_mode);

  always_comb begin
    case (phase)
      PH_BLANK: last_pos = DW'(BLANK_STEPS - 1);
      PH_DELAY: last_pos = DW'(DELAY_STEPS - 1);
      default:  last_pos = DW'(PWM_LEN - 1);
    endcase
  end

  assign at_last = (pos == last_pos);
  assign row_end = step && (phase == PH_ACTIVE) && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_BLANK;
      pos   <= '0;
      row   <= '0;
    end else if (step) begin
      if (at_last) begin
        pos <= '0;
        case (phase)
          PH_BLANK: phase <= PH_DELAY;
          PH_DELAY: phase <= PH_ACTIVE;
          default: begin
            phase <= PH_BLANK;
            if (sink_only || ({1'b0, row} + 3'd1) >= nrows) row <= '0;
            else                                            row <= row + RW'(1);
          end
        endcase
      end else begin
        pos <= pos + DW'(1);
      end
    end
  end

  AST_ROW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(row)) |-> $past(row_end)) else $error("row jump"); // R3
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(phase) == PH_BLANK && phase != PH_BLANK) |-> phase == PH_DELAY) else $error("phase order"); // R2

endmodule

// File: rtl/sink_pwm_bank.sv
module sink_pwm_bank #(
  parameter int COLS = 18
) (
  input  logic                     run,
  input  logic                     phase_180,
  input  ledscan_pkg::scan_phase_e phase,
  input  logic [ledscan_pkg::DW-1:0] pos,
  input  logic [$clog2(ledscan_pkg::ROWS)-1:0] row,
  input  logic [ledscan_pkg::DW*ledscan_pkg::ROWS*COLS-1:0] duty_bytes,
  output logic [COLS-1:0]          cs_en
);
  import ledscan_pkg::*;

  localparam int BW = DW * COLS;

  logic [BW-1:0] row_bytes;
  logic          active;

  assign row_bytes = duty_bytes[row*BW +: BW];
  assign active    = run && (phase == PH_ACTIVE);

  for (genvar c = 0; c < COLS; c++) begin : g_sink
    localparam bit LATE_HALF = (c >= COLS / 2);
    logic [DW-1:0] duty;
    assign duty     = row_bytes[c*DW +: DW];
    assign cs_en[c] = active && pwm_window(pos, duty, phase_180 && LATE_HALF);
  end

endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq #(
  parameter int COLS        = 18,
  parameter int BLANK_STEPS = 6,
  parameter int DELAY_STEPS = 2,
  parameter int MAX_SHIFT   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [3:0]          scan_mode,
  input  logic [2:0]          freq_code,
  input  logic                phase_180,
  input  logic [ledscan_pkg::DW*ledscan_pkg::ROWS*COLS-1:0] duty_bytes,
  output logic [ledscan_pkg::ROWS-1:0] sw_en,
  output logic [COLS-1:0]     cs_en
);
  import ledscan_pkg::*;

  localparam int RW = $clog2(ROWS);

  logic          step;
  scan_phase_e   phase;
  logic [DW-1:0] pos;
  logic [RW-1:0] row;
  logic          row_end;
  logic          sink_only;

  scan_step_gen #(.MAX_SHIFT(MAX_SHIFT)) u_step (
    .clk(clk), .rst_n(rst_n), .run(run), .freq_code(freq_code), .step(step)
  );

  scan_row_fsm #(.BLANK_STEPS(BLANK_STEPS), .DELAY_STEPS(DELAY_STEPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .scan_mode(scan_mode),
    .phase(phase), .pos(pos), .row(row), .row_end(row_end), .sink_only(sink_only)
  );

  sink_pwm_bank #(.COLS(COLS)) u_sinks (
    .run(run), .phase_180(phase_180), .phase(phase), .pos(pos), .row(row),
    .duty_bytes(duty_bytes), .cs_en(cs_en)
  );

  assign sw_en = (run && !sink_only && phase != PH_BLANK) ? (ROWS'(1) << row) : '0;

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en)) else $error("two rows on"); // R1
  AST_SINK_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cs_en) && !sink_only) |-> (|sw_en)) else $error("sink without row"); // R2
  AST_SINK_ONLY_DARK_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    sink_only |-> sw_en == '0) else $error("switch in sink-only"); // R4
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sw_en == '0 && cs_en == '0)) else $error("lit in shutdown"); // R8

endmodule

// File: tb/led_scan_seq_bench.sv
module led_scan_seq_bench;

  localparam int COLS = 18;
  localparam int ROWS = 4;
  localparam int NB   = ROWS * COLS;
  localparam int B    = 6;
  localparam int D    = 2;
  localparam int P    = B + D + 256;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              run = 0;
  logic [3:0]        scan_mode = 0;
  logic [2:0]        freq_code = 0;
  logic              phase_180 = 0;
  logic [8*NB-1:0]   duty_bus;
  logic [ROWS-1:0]   sw_en;
  logic [COLS-1:0]   cs_en;
  logic [7:0]        dmem [NB];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [ROWS-1:0] sw;
    logic [COLS-1:0] cs;
    string           tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NB; k++) duty_bus[k*8 +: 8] = dmem[k];
  end

  led_scan_seq u_led_scan_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .scan_mode(scan_mode),
    .freq_code(freq_code), .phase_180(phase_180), .duty_bytes(duty_bus),
    .sw_en(sw_en), .cs_en(cs_en)
  );

  // expected outputs after n enabled edges, restated from the requirements
  function automatic exp_t model(int n, logic [3:0] m, logic [2:0] fc, logic ph, string tag);
    exp_t e;
    int sh, t, nr, r, p, a, w;
    sh = (fc == 3'd7) ? 0 : int'(fc);
    t  = n >> sh;
    nr = (m == 4'd1) ? 3 : (m == 4'd2) ? 2 : (m == 4'd3) ? 1 : 4;
    r  = (t / P) % nr;
    p  = t % P;
    e.sw = (m != 4'd3 && p >= B) ? ROWS'(1 << r) : '0;
    e.cs = '0;
    if (p >= B + D) begin
      a = p - B - D;
      for (int c = 0; c < COLS; c++) begin
        w = (ph && c >= COLS / 2) ? (a + 128) % 256 : a;
        e.cs[c] = (w < int'(dmem[r*COLS + c]));
      end
    end
    e.tag = tag;
    return e;
  endfunction

  // monitor: pop one expectation per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sw_en !== e.sw || cs_en !== e.cs) begin
        fails++;
        $display("FAIL %s: sw_en=%b exp %b, cs_en=%h exp %h", e.tag, sw_en, e.sw, cs_en, e.cs);
      end
    end
  end

  task automatic run_off(int cyc, string tag);
    exp_t z;
    z.sw = '0; z.cs = '0; z.tag = tag;
    run = 0;
    for (int i = 0; i < cyc; i++) q.push_back(z);
    repeat (cyc) @(negedge clk);
    #1;
  endtask

  task automatic run_cfg(logic [3:0] m, logic [2:0] fc, logic ph, int cyc, string tag);
    run_off(2, "R8 restart gap");
    scan_mode = m; freq_code = fc; phase_180 = ph;
    run = 1;
    for (int n = 1; n <= cyc; n++) q.push_back(model(n, m, fc, ph, tag));
    repeat (cyc) @(negedge clk);
    #1;
  endtask

  task automatic fill(int mul, int add);
    for (int k = 0; k < NB; k++) dmem[k] = 8'((k * mul + add) % 256);
    dmem[0] = 8'd0; dmem[1] = 8'd255; dmem[9] = 8'd255; dmem[10] = 8'd128;
    dmem[COLS] = 8'd1; dmem[2*COLS+17] = 8'd255; dmem[3*COLS+12] = 8'd0;
  endtask

  initial begin
    fill(53, 17);
    run = 1; scan_mode = 4'd0;
    repeat (3) @(negedge clk);
    checks++;  // reset state
    if (sw_en !== '0 || cs_en !== '0) begin
      fails++;
      $display("FAIL R2 reset: sw_en=%b exp 0, cs_en=%h exp 0", sw_en, cs_en);
    end
    #1; run = 0; rst_n = 1;
    @(negedge clk); #1;

    run_cfg(4'd0,  3'd0, 1'b0, 1100, "R1 R2 R3 R6 four rows");
    run_cfg(4'd1,  3'd0, 1'b0, 850,  "R3 three rows");
    run_cfg(4'd2,  3'd0, 1'b0, 600,  "R3 two rows");
    run_cfg(4'd3,  3'd0, 1'b0, 600,  "R4 sink only");
    run_cfg(4'd9,  3'd0, 1'b0, 1100, "R3 other code");
    run_cfg(4'd0,  3'd1, 1'b0, 1100, "R5 code 1");
    run_cfg(4'd0,  3'd6, 1'b0, 900,  "R5 code 6");
    run_cfg(4'd0,  3'd7, 1'b0, 600,  "R5 code 7");
    run_cfg(4'd0,  3'd0, 1'b1, 1100, "R7 phase shift");
    fill(29, 200);
    run_cfg(4'd2,  3'd0, 1'b1, 600,  "R6 R7 second pattern");
    run_cfg(4'd3,  3'd2, 1'b1, 1100, "R4 R5 R7 sink only slow");
    run_cfg(4'd0,  3'd0, 1'b0, 400,  "R6 before shutdown");
    run_off(20, "R8 shutdown dark");
    run_cfg(4'd0,  3'd0, 1'b0, 300,  "R8 restart from row 0");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule